// File: doc/BRIEF.md
# Coded-Ratio Clock Divider Bank

This block derives three groups of slower clock-like signals from one selected source. A select input picks the source: a fast clock or a reference clock. Both sources arrive as level signals and are oversampled by the block clock `clk`. Each source must stay high and low for at least one `clk` cycle. Every group is called a bank: bank A, bank B and a feedback bank. Each bank divides the selected source by a ratio picked with its own 3-bit code. The ratio set is not uniform and includes odd values.

Bank A and bank B each fan out to three identical outputs. The feedback bank drives a single output. Every true output has a complementary output that is its plain inversion.

An active-low hold input stops all dividers and forces every true output low. The three banks share one edge detector on the selected source and are released together. As a result, their rising edges line up. A new ratio code waits until the bank's current period ends, so no short pulse is ever produced.

Top module: `div_bank`

## Requirements
- R1: A bank's 3-bit code gives its divide ratio: 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8, 7→10 (code read as an unsigned number).
- R2: Bank A (`code_a`), bank B (`code_b`) and the feedback bank (`code_fb`) divide independently, each by the ratio of its own code.
- R3: While `rst_n` is low at a `clk` edge, every true output is low after that edge and every complementary output is high.
- R4: After `rst_n` returns high, each bank with ratio 2 or more raises its output on the first rising edge of the selected source.
- R5: For ratio N ≥ 2, the output is high for floor(N/2) source periods and low for ceil(N/2) source periods. It changes only at source rising edges.
- R6: With ratio 1, the output copies the selected source level one `clk` cycle late, and it is gated low by `rst_n`.
- R7: `sel_fast` high selects `fast_src` as the divider source. Low selects `ref_src`.
- R8: The three bank A outputs are always equal, as are the three bank B outputs. Each `_n` output is the inverse of its true output.
- R9: After release, all banks rise on the same `clk` cycle. They rise together again at every common multiple of their ratios.
- R10: A code change takes effect only at the bank's terminal count. The period already in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rst_n | input | 1 | Active-low hold; synchronous to `clk` |
| sel_fast | input | 1 | Source select: 1 = fast source, 0 = reference |
| fast_src | input | 1 | Fast source level |
| ref_src | input | 1 | Reference source level |
| code_a | input | 3 | Ratio code of bank A |
| code_b | input | 3 | Ratio code of bank B |
| code_fb | input | 3 | Ratio code of the feedback bank |
| qa | output | NUM_A | Bank A true outputs |
| qa_n | output | NUM_A | Bank A complementary outputs |
| qb | output | NUM_B | Bank B true outputs |
| qb_n | output | NUM_B | Bank B complementary outputs |
| qfb | output | 1 | Feedback true output |
| qfb_n | output | 1 | Feedback complementary output |

## Verification
The bench measures high and low run lengths for all eight codes.

- If the decode is wrong, or odd ratios are rounded the wrong way, the run lengths come out wrong. An odd ratio with high and low times swapped shows up as inverted run lengths.
- The alignment test releases the hold with ratios 2, 3 and 6 and checks two things: all three banks rise on the first common edge and again at the 24-cycle common multiple. A bank started from the wrong count value would miss one of these points.
- A code switched in the middle of a high phase must leave that period at full length. A design that reloads at once would cut it short and produce a runt.
- Ratio 1 is compared sample by sample against the delayed source, which catches a pass-through that ignores the hold or the select.

// File: rtl/div_bank_pkg.sv
package div_bank_pkg;

    localparam int CODE_W    = 3;
    localparam int MAX_RATIO = 10;
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef logic [CODE_W-1:0] ratio_code_t;
    typedef logic [CNT_W-1:0]  ratio_t;

    // Running state of one bank divider.
    typedef struct packed {
        ratio_t ratio;   // ratio in force for the current period
        ratio_t cnt;     // source periods elapsed in this output period
        logic   q;       // registered true output
    } div_state_t;

    // Nonuniform ratio set selected by a 3-bit code.
    function automatic ratio_t code_to_ratio(input ratio_code_t c);
        case (c)
            3'd0:    return ratio_t'(1);
            3'd1:    return ratio_t'(2);
            3'd2:    return ratio_t'(3);
            3'd3:    return ratio_t'(4);
            3'd4:    return ratio_t'(5);
            3'd5:    return ratio_t'(6);
            3'd6:    return ratio_t'(8);
            default: return ratio_t'(10);
        endcase
    endfunction

    // Source periods spent high: half the ratio, rounded down.
    function automatic ratio_t high_span(input ratio_t n);
        return n >> 1;
    endfunction

endpackage

// File: rtl/src_edge.sv
module src_edge (
    input  logic clk,
    input  logic sel_fast,
    input  logic fast_src,
    input  logic ref_src,
    output logic src_lvl,
    output logic src_rise
);
    logic src_d;

    assign src_lvl = sel_fast ? fast_src : ref_src;

    always_ff @(posedge clk) begin
        src_d <= src_lvl;
    end

    assign src_rise = src_lvl & ~src_d;

endmodule

// File: rtl/ratio_div.sv
module ratio_div
    import div_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ratio_code_t code,
    input  logic        src_lvl,
    input  logic        src_rise,
    output logic        q
);
    div_state_t st;
    logic       wrap;
    ratio_t     eff_ratio;
    ratio_t     cnt_nx;
    logic       q_nx;
    ratio_t     load_ratio;

    assign load_ratio = code_to_ratio(code);

    always_comb begin
        wrap      = src_rise && (st.cnt == ratio_t'(st.ratio - ratio_t'(1)));
        eff_ratio = wrap ? load_ratio : st.ratio;
        if (!src_rise)
            cnt_nx = st.cnt;
        else if (wrap)
            cnt_nx = '0;
        else
            cnt_nx = ratio_t'(st.cnt + ratio_t'(1));
        if (eff_ratio == ratio_t'(1))
            q_nx = src_lvl;
        else if (src_rise)
            q_nx = (cnt_nx < high_span(eff_ratio));
        else
            q_nx = st.q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.ratio <= load_ratio;
            st.cnt   <= ratio_t'(load_ratio - ratio_t'(1));
            st.q     <= 1'b0;
        end else begin
            st.ratio <= eff_ratio;
            st.cnt   <= cnt_nx;
            st.q     <= q_nx;
        end
    end

    assign q = st.q;

    assert_reset_low_R3: assert property (@(posedge clk)
        !rst_n |=> !q);

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st.cnt < st.ratio);

    assert_ratio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st.ratio != $past(st.ratio)) |-> ($past(wrap) || $past(!rst_n)));

    assert_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st.ratio) != ratio_t'(1)) && (st.ratio != ratio_t'(1)) && (q != $past(q)))
        |-> ($past(src_rise) || $past(!rst_n)));

endmodule

// File: rtl/div_bank.sv
module div_bank
    import div_bank_pkg::*;
#(
    parameter int NUM_A = 3,
    parameter int NUM_B = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_fast,
    input  logic             fast_src,
    input  logic             ref_src,
    input  logic [2:0]       code_a,
    input  logic [2:0]       code_b,
    input  logic [2:0]       code_fb,
    output logic [NUM_A-1:0] qa,
    output logic [NUM_A-1:0] qa_n,
    output logic [NUM_B-1:0] qb,
    output logic [NUM_B-1:0] qb_n,
    output logic             qfb,
    output logic             qfb_n
);
    localparam int NUM_BANKS = 3;
    localparam int BANK_A    = 0;
    localparam int BANK_B    = 1;
    localparam int BANK_FB   = 2;

    logic                 src_lvl;
    logic                 src_rise;
    ratio_code_t          bank_code [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_q;

    assign bank_code[BANK_A]  = code_a;
    assign bank_code[BANK_B]  = code_b;
    assign bank_code[BANK_FB] = code_fb;

    src_edge u_src (
        .clk      (clk),
        .sel_fast (sel_fast),
        .fast_src (fast_src),
        .ref_src  (ref_src),
        .src_lvl  (src_lvl),
        .src_rise (src_rise)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ratio_div u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (bank_code[g]),
            .src_lvl  (src_lvl),
            .src_rise (src_rise),
            .q        (bank_q[g])
        );
    end

    assign qa    = {NUM_A{bank_q[BANK_A]}};
    assign qb    = {NUM_B{bank_q[BANK_B]}};
    assign qfb   = bank_q[BANK_FB];
    assign qa_n  = ~qa;
    assign qb_n  = ~qb;
    assign qfb_n = ~qfb;

endmodule

// File: tb/test_div_bank.sv
module test_div_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_fast = 1'b1;
    logic       fast_src = 1'b0;
    logic       ref_src = 1'b0;
    logic [2:0] code_a = 3'd0;
    logic [2:0] code_b = 3'd0;
    logic [2:0] code_fb = 3'd0;
    logic [2:0] qa, qa_n, qb, qb_n;
    logic       qfb, qfb_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int fcnt = 0;
    int rcnt = 0;

    localparam int FP = 4;  // fast source period in clk cycles, half high
    localparam int RP = 6;  // reference source period in clk cycles, half high

    div_bank i_div_bank (
        .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast),
        .fast_src(fast_src), .ref_src(ref_src),
        .code_a(code_a), .code_b(code_b), .code_fb(code_fb),
        .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n),
        .qfb(qfb), .qfb_n(qfb_n)
    );

    always #5 clk = ~clk;

    // Registered source generators.
    always @(posedge clk) begin
        fcnt     <= (fcnt == FP - 1) ? 0 : fcnt + 1;
        fast_src <= (fcnt < FP / 2);
        rcnt     <= (rcnt == RP - 1) ? 0 : rcnt + 1;
        ref_src  <= (rcnt < RP / 2);
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic pick(input int idx);
        case (idx)
            0:       return qa[0];
            1:       return qb[0];
            default: return qfb;
        endcase
    endfunction

    function automatic int ratio_of(input int code);
        int tbl[8] = '{1, 2, 3, 4, 5, 6, 8, 10};
        return tbl[code];
    endfunction

    // Waits for a rising output, then measures high and low run lengths.
    task automatic measure(input int idx, output int hi, output int lo);
        logic prev;
        int   n;
        hi = 0; lo = 0; n = 0;
        @(negedge clk); prev = pick(idx);
        forever begin
            @(negedge clk);
            if (!prev && pick(idx)) break;
            prev = pick(idx);
            if (++n > 400) begin hi = -1; return; end
        end
        while (pick(idx) && hi < 400) begin hi++; @(negedge clk); end
        while (!pick(idx) && lo < 400) begin lo++; @(negedge clk); end
    endtask

    task automatic restart;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b1; code_a = 3'd1; code_b = 3'd0; code_fb = 3'd0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3", "true outputs low one edge after hold", {qa, qb, qfb}, 0);
        check("R3", "complements high during hold", {qa_n, qb_n, qfb_n}, 7'h7f);
        begin
            int bad = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if ({qa, qb, qfb} != 0) bad++;
            end
            check("R3", "outputs stay low while held", bad, 0);
        end
    endtask

    task automatic t_decode;
        int hi, lo, n;
        sel_fast = 1'b1;
        for (int c = 0; c < 8; c++) begin
            code_fb = 3'(c);
            restart();
            measure(2, hi, lo);
            n = ratio_of(c);
            check("R1", $sformatf("code %0d high time", c), hi, (n == 1) ? FP / 2 : (n / 2) * FP);
            check("R5", $sformatf("code %0d low time", c), lo, (n == 1) ? FP / 2 : (n - n / 2) * FP);
        end
    endtask

    task automatic t_ratio1;
        logic prev_src;
        int   bad = 0;
        code_fb = 3'd0; sel_fast = 1'b1;
        restart();
        @(negedge clk); prev_src = fast_src;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (qfb != prev_src) bad++;
            prev_src = fast_src;
        end
        check("R6", "ratio 1 follows source delayed one cycle", bad, 0);
    endtask

    task automatic t_independent;
        int hi, lo;
        code_a = 3'd2; code_b = 3'd6; code_fb = 3'd4;
        restart();
        measure(0, hi, lo);
        check("R2", "bank A ratio 3 high", hi, 1 * FP);
        check("R2", "bank A ratio 3 low", lo, 2 * FP);
        measure(1, hi, lo);
        check("R2", "bank B ratio 8 period", hi + lo, 8 * FP);
        measure(2, hi, lo);
        check("R2", "feedback ratio 5 high", hi, 2 * FP);
        check("R2", "feedback ratio 5 low", lo, 3 * FP);
    endtask

    task automatic t_fanout;
        int bad = 0;
        code_a = 3'd2; code_b = 3'd4; code_fb = 3'd1;
        restart();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!(qa == 3'b000 || qa == 3'b111)) bad++;
            if (!(qb == 3'b000 || qb == 3'b111)) bad++;
            if (qa_n != ~qa || qb_n != ~qb || qfb_n != ~qfb) bad++;
        end
        check("R8", "bank fanout and complements", bad, 0);
    endtask

    task automatic t_select;
        int hi, lo;
        code_fb = 3'd1; sel_fast = 1'b0;
        restart();
        measure(2, hi, lo);
        check("R7", "reference source ratio 2 high", hi, RP);
        check("R7", "reference source ratio 2 low", lo, RP);
        sel_fast = 1'b1;
    endtask

    task automatic t_align;
        logic pa, pb, pf;
        int   n = 0;
        code_a = 3'd1; code_b = 3'd2; code_fb = 3'd5; sel_fast = 1'b1;
        restart();
        while (!(qa[0] || qb[0] || qfb) && n < 100) begin @(negedge clk); n++; end
        check("R4", "first rise within one source period of release", int'(n <= FP + 1), 1);
        check("R9", "all banks rise together after release", {qa[0], qb[0], qfb}, 3'b111);
        pf = qfb; n = 0;
        forever begin
            pa = qa[0]; pb = qb[0]; pf = qfb;
            @(negedge clk); n++;
            if ((!pf && qfb) || n > 200) break;
        end
        check("R9", "feedback period at ratio 6", n, 6 * FP);
        check("R9", "A and B rise at the common multiple", {!pa && qa[0], !pb && qb[0]}, 2'b11);
    endtask

    task automatic t_defer;
        logic prev;
        int   hi = 0, lo = 0, n = 0;
        code_fb = 3'd7; sel_fast = 1'b1;
        restart();
        @(negedge clk); prev = qfb;
        while (!(!prev && qfb) && n < 400) begin prev = qfb; @(negedge clk); n++; end
        while (qfb && hi < 400) begin
            hi++;
            if (hi == 5) code_fb = 3'd1;
            @(negedge clk);
        end
        while (!qfb && lo < 400) begin lo++; @(negedge clk); end
        check("R10", "period in progress keeps old high time", hi, 5 * FP);
        check("R10", "period in progress keeps old low time", lo, 5 * FP);
        hi = 0; lo = 0;
        while (qfb && hi < 400) begin hi++; @(negedge clk); end
        while (!qfb && lo < 400) begin lo++; @(negedge clk); end
        check("R10", "new ratio 2 high after terminal count", hi, FP);
        check("R10", "new ratio 2 low after terminal count", lo, FP);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3", "reset state true outputs", {qa, qb, qfb}, 0);
        check("R8", "reset state complements", {qa_n, qb_n, qfb_n}, 7'h7f);
        t_reset();
        t_decode();
        t_ratio1();
        t_independent();
        t_fanout();
        t_select();
        t_align();
        t_defer();
        finish_run();
    end

endmodule